// File: doc/BRIEF.md
# Write-Deferred Atomic Commit Register Group

This block is a small group of wide registers behind a 32-bit CPU write port. Each register spans several bus words. A register can be set up to defer software writes. Such a write, including a write with only some byte strobes set, is collected in a staging store that belongs to that register alone. The register's real value does not change until a commit event. On that event, every byte gathered so far is copied into the register in one clock edge. Software can therefore update a 64-bit value, or a whole set of registers, without any observer seeing a half-written state.

A per-register parameter selects the commit source. The source can be a write to the register's own top sub-word, a write to the top sub-word of another register that several registers share, or an external pin with selectable polarity. A register can also be left direct, so that writes take effect at once. The block drives every register value as a flat vector, a one-cycle write pulse per register that marks the cycle in which its stored value is updated, and a combinational read-back port indexed by word address.

Top module: `wdc_reg_group`

## Requirements
- R1: While reset is asserted and right after it is released, every register value, every write pulse and read-back data are all zero, and data staged before the reset is lost.
- R2: A write to a deferred register leaves its value and its read-back unchanged until a commit event.
- R3: With the default configuration, register 0 commits when its top sub-word (word address 1) is written. Bytes staged in all of its sub-words appear together after that clock edge.
- R4: Byte strobe bit b covers data bits 8b+7..8b of the word. At commit, only bytes that were written since the last commit change. A top-word write with no strobe bits set still commits, and the value stays unchanged.
- R5: Registers 1 and 2 share a trigger: a write to the top word of register 4 (address 9). That write commits both in the same cycle. A write to address 8 commits neither.
- R6: Register 3 commits while the external trigger is at its active level (active-high by default). Its write pulse rises in the trigger cycle, and the new value is visible in the following cycle.
- R7: A trigger event is ignored for a deferred register that holds no pending write: no pulse, and the value is unchanged.
- R8: The write pulse of a deferred register fires in the commit cycle only, never in the cycle of a staged write, and lasts one cycle.
- R9: Register 4 is direct. A write updates it after the same edge, and its pulse rises in the write cycle.
- R10: When a staged write and its trigger fall in the same cycle, the new write data is part of that commit.
- R11: Sub-word k of register r sits at word address 2r+k, and k=0 holds bits 31..0. Read-back returns the committed value of the addressed word. Addresses 10 to 15 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write valid |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 32 | Write data |
| wr_strb | input | 4 | Byte enables of the write |
| commit_trig | input | 1 | External commit trigger |
| rd_addr | input | 4 | Word address for read-back |
| rd_data | output | 32 | Committed value of the addressed word |
| reg_values | output | 320 | All register values, register r at bits 64r+63..64r |
| reg_wr_pulse | output | 5 | Per-register write pulse in the update cycle |

## Verification
A staged write and its own trigger can fall in the same cycle. This happens when the final sub-word of a self-committing register is written, when a data word and the external trigger arrive together, and when a write to the shared trigger register also updates that direct register. The bench sets up each of these cases, then checks that the pulse vector in that cycle names exactly the registers that commit. After the next edge it reads back the merged word to confirm that the same-cycle bytes are included. It also fires triggers with nothing pending, and checks that the read-back in the trigger cycle still shows the old value.

// File: rtl/wdc_pkg.sv
package wdc_pkg;

  // Commit source selected per register (2-bit field in TRIG_MODES).
  typedef enum logic [1:0] {
    TRIG_NONE = 2'd0,  // direct register, no staging
    TRIG_SELF = 2'd1,  // write to own top sub-word
    TRIG_PEER = 2'd2,  // write to top sub-word of another register
    TRIG_EXT  = 2'd3   // external pin
  } trig_mode_e;

endpackage

// File: rtl/wdc_decode.sv
module wdc_decode #(
  parameter int unsigned NUM_REGS  = 5,
  parameter int unsigned REG_WORDS = 2,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned WSEL_W    = 1
) (
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  output logic [NUM_REGS-1:0] hit,
  output logic [WSEL_W-1:0]   word_sel
);

  logic [31:0] addr32;

  assign addr32   = 32'(wr_addr);
  assign word_sel = WSEL_W'(addr32 % 32'(REG_WORDS));

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_hit
    assign hit[r] = wr_en
                 && (addr32 >= 32'(r * REG_WORDS))
                 && (addr32 <  32'((r + 1) * REG_WORDS));
  end

endmodule

// File: rtl/wdc_stage_buf.sv
module wdc_stage_buf #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned REG_WORDS = 2,
  parameter int unsigned WSEL_W    = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_hit,
  input  logic [WSEL_W-1:0]             word_sel,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [DATA_W/8-1:0]           wr_strb,
  input  logic                          trig,
  output logic [DATA_W*REG_WORDS-1:0]   value_o,
  output logic                          strobe_o
);

  localparam int unsigned STRB_W    = DATA_W / 8;
  localparam int unsigned REG_W     = DATA_W * REG_WORDS;
  localparam int unsigned REG_BYTES = REG_W / 8;

  logic [REG_W-1:0]     in_data, staged, merged;
  logic [REG_BYTES-1:0] in_mask;
  logic [REG_W-1:0]     stage_q, stage_d, value_q, value_d;
  logic [REG_BYTES-1:0] mask_q, mask_d;
  logic                 pend_q, pend_d;
  logic                 fire, stage_en, value_en;

  // Place the incoming word at its sub-word slot.
  always_comb begin
    in_data = '0;
    in_mask = '0;
    for (int w = 0; w < REG_WORDS; w++) begin
      if (wr_hit && (word_sel == WSEL_W'(w))) begin
        in_data[w*DATA_W +: DATA_W] = wr_data;
        in_mask[w*STRB_W +: STRB_W] = wr_strb;
      end
    end
  end

  // Byte merge: new write over staged bytes over current value.
  always_comb begin
    for (int b = 0; b < REG_BYTES; b++) begin
      staged[b*8 +: 8] = in_mask[b] ? in_data[b*8 +: 8] : stage_q[b*8 +: 8];
      if (in_mask[b])
        merged[b*8 +: 8] = in_data[b*8 +: 8];
      else if (mask_q[b])
        merged[b*8 +: 8] = stage_q[b*8 +: 8];
      else
        merged[b*8 +: 8] = value_q[b*8 +: 8];
    end
  end

  // Next-state for staging and register storage.
  always_comb begin
    fire     = trig && (pend_q || wr_hit);
    stage_en = wr_hit || fire;
    value_en = fire;
    value_d  = merged;
    if (fire) begin
      stage_d = stage_q;
      mask_d  = '0;
      pend_d  = 1'b0;
    end else begin
      stage_d = staged;
      mask_d  = mask_q | in_mask;
      pend_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      mask_q  <= '0;
      pend_q  <= 1'b0;
    end else if (stage_en) begin
      stage_q <= stage_d;
      mask_q  <= mask_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
    end else if (value_en) begin
      value_q <= value_d;
    end
  end

  assign value_o  = value_q;
  assign strobe_o = fire;

endmodule

// File: rtl/wdc_stage_direct.sv
module wdc_stage_direct #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned REG_WORDS = 2,
  parameter int unsigned WSEL_W    = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_hit,
  input  logic [WSEL_W-1:0]             word_sel,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [DATA_W/8-1:0]           wr_strb,
  output logic [DATA_W*REG_WORDS-1:0]   value_o,
  output logic                          strobe_o
);

  localparam int unsigned STRB_W    = DATA_W / 8;
  localparam int unsigned REG_W     = DATA_W * REG_WORDS;
  localparam int unsigned REG_BYTES = REG_W / 8;

  logic [REG_W-1:0]     in_data, value_q, value_d;
  logic [REG_BYTES-1:0] in_mask;
  logic                 value_en;

  always_comb begin
    in_data = '0;
    in_mask = '0;
    for (int w = 0; w < REG_WORDS; w++) begin
      if (wr_hit && (word_sel == WSEL_W'(w))) begin
        in_data[w*DATA_W +: DATA_W] = wr_data;
        in_mask[w*STRB_W +: STRB_W] = wr_strb;
      end
    end
  end

  always_comb begin
    value_en = wr_hit;
    for (int b = 0; b < REG_BYTES; b++)
      value_d[b*8 +: 8] = in_mask[b] ? in_data[b*8 +: 8] : value_q[b*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
    end else if (value_en) begin
      value_q <= value_d;
    end
  end

  assign value_o  = value_q;
  assign strobe_o = wr_hit;

endmodule

// File: rtl/wdc_readmux.sv
module wdc_readmux #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 10,
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [WORDS*DATA_W-1:0] values,
  output logic [DATA_W-1:0]       rd_data
);

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (rd_addr == ADDR_W'(w))
        rd_data = values[w*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/wdc_reg_group.sv
module wdc_reg_group
  import wdc_pkg::*;
#(
  parameter int unsigned DATA_W          = 32,
  parameter int unsigned REG_WORDS       = 2,
  parameter int unsigned NUM_REGS        = 5,
  // 2 bits per register, register 0 in the low bits
  parameter logic [2*NUM_REGS-1:0] TRIG_MODES = {2'd0, 2'd3, 2'd2, 2'd2, 2'd1},
  // 8 bits per register: index of the register whose top word commits it
  parameter logic [8*NUM_REGS-1:0] PEER_SEL   = {8'd4, 8'd4, 8'd4, 8'd4, 8'd4},
  parameter bit          EXT_ACTIVE_HIGH = 1'b1,
  localparam int unsigned STRB_W   = DATA_W / 8,
  localparam int unsigned REG_W    = DATA_W * REG_WORDS,
  localparam int unsigned WORDS    = NUM_REGS * REG_WORDS,
  localparam int unsigned ADDR_W   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [STRB_W-1:0]         wr_strb,
  input  logic                      commit_trig,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  output logic [NUM_REGS*REG_W-1:0] reg_values,
  output logic [NUM_REGS-1:0]       reg_wr_pulse
);

  localparam int unsigned WSEL_W = (REG_WORDS > 1) ? $clog2(REG_WORDS) : 1;
  localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(REG_WORDS - 1);

  logic [NUM_REGS-1:0] hit;
  logic [WSEL_W-1:0]   word_sel;
  logic                ext_active;

  assign ext_active = EXT_ACTIVE_HIGH ? commit_trig : ~commit_trig;

  wdc_decode #(
    .NUM_REGS (NUM_REGS),
    .REG_WORDS(REG_WORDS),
    .ADDR_W   (ADDR_W),
    .WSEL_W   (WSEL_W)
  ) u_decode (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .hit     (hit),
    .word_sel(word_sel)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    localparam logic [1:0] MODE = TRIG_MODES[2*r +: 2];

    if (MODE == TRIG_NONE) begin : g_direct
      wdc_stage_direct #(
        .DATA_W   (DATA_W),
        .REG_WORDS(REG_WORDS),
        .WSEL_W   (WSEL_W)
      ) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (hit[r]),
        .word_sel(word_sel),
        .wr_data (wr_data),
        .wr_strb (wr_strb),
        .value_o (reg_values[r*REG_W +: REG_W]),
        .strobe_o(reg_wr_pulse[r])
      );
    end else begin : g_buf
      logic trig_r;

      if (MODE == TRIG_SELF) begin : g_self
        assign trig_r = hit[r] && (word_sel == LAST_WORD);
      end else if (MODE == TRIG_PEER) begin : g_peer
        localparam int unsigned PIDX = int'(PEER_SEL[8*r +: 8]);
        assign trig_r = hit[PIDX] && (word_sel == LAST_WORD);
      end else begin : g_ext
        assign trig_r = ext_active;
      end

      wdc_stage_buf #(
        .DATA_W   (DATA_W),
        .REG_WORDS(REG_WORDS),
        .WSEL_W   (WSEL_W)
      ) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (hit[r]),
        .word_sel(word_sel),
        .wr_data (wr_data),
        .wr_strb (wr_strb),
        .trig    (trig_r),
        .value_o (reg_values[r*REG_W +: REG_W]),
        .strobe_o(reg_wr_pulse[r])
      );
    end
  end

  wdc_readmux #(
    .DATA_W(DATA_W),
    .WORDS (WORDS),
    .ADDR_W(ADDR_W)
  ) u_readmux (
    .rd_addr(rd_addr),
    .values (reg_values),
    .rd_data(rd_data)
  );

endmodule

// File: rtl/wdc_reg_group_chk.sv
module wdc_reg_group_chk
  import wdc_pkg::*;
#(
  parameter int unsigned DATA_W          = 32,
  parameter int unsigned REG_WORDS       = 2,
  parameter int unsigned NUM_REGS        = 5,
  parameter logic [2*NUM_REGS-1:0] TRIG_MODES = {2'd0, 2'd3, 2'd2, 2'd2, 2'd1},
  parameter logic [8*NUM_REGS-1:0] PEER_SEL   = {8'd4, 8'd4, 8'd4, 8'd4, 8'd4},
  parameter bit          EXT_ACTIVE_HIGH = 1'b1,
  localparam int unsigned STRB_W   = DATA_W / 8,
  localparam int unsigned REG_W    = DATA_W * REG_WORDS,
  localparam int unsigned WORDS    = NUM_REGS * REG_WORDS,
  localparam int unsigned ADDR_W   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [ADDR_W-1:0]         wr_addr,
  input logic [DATA_W-1:0]         wr_data,
  input logic [STRB_W-1:0]         wr_strb,
  input logic                      commit_trig,
  input logic [ADDR_W-1:0]         rd_addr,
  input logic [DATA_W-1:0]         rd_data,
  input logic [NUM_REGS*REG_W-1:0] reg_values,
  input logic [NUM_REGS-1:0]       reg_wr_pulse
);

  logic ext_on;
  assign ext_on = (commit_trig == EXT_ACTIVE_HIGH);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_r
    localparam logic [1:0] MODE = TRIG_MODES[2*r +: 2];
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(r*REG_WORDS + REG_WORDS - 1);

    // R2
    value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr_pulse[r] |=> $stable(reg_values[r*REG_W +: REG_W]));

    if (MODE == TRIG_NONE) begin : g_direct
      for (genvar k = 0; k < REG_WORDS; k++) begin : g_k
        localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(r*REG_WORDS + k);
        // R9
        direct_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (wr_en && wr_addr == WADDR) |-> reg_wr_pulse[r]);
        // R9
        direct_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (wr_en && wr_addr == WADDR && (&wr_strb))
          |=> reg_values[r*REG_W + k*DATA_W +: DATA_W] == $past(wr_data));
      end
    end else if (MODE == TRIG_SELF) begin : g_self
      // R3
      self_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == TOP_ADDR) |-> reg_wr_pulse[r]);
    end else if (MODE == TRIG_PEER) begin : g_peer
      localparam int unsigned PIDX = int'(PEER_SEL[8*r +: 8]);
      localparam logic [ADDR_W-1:0] PEER_TOP = ADDR_W'(PIDX*REG_WORDS + REG_WORDS - 1);
      // R5
      peer_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_pulse[r] |-> (wr_en && wr_addr == PEER_TOP));
    end else begin : g_ext
      // R6
      ext_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_pulse[r] |-> ext_on);
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_rd
    // R11
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(w)) |-> rd_data == reg_values[w*DATA_W +: DATA_W]);
  end

  // R11
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rd_addr) >= WORDS) |-> rd_data == '0);

endmodule

bind wdc_reg_group wdc_reg_group_chk #(
  .DATA_W         (DATA_W),
  .REG_WORDS      (REG_WORDS),
  .NUM_REGS       (NUM_REGS),
  .TRIG_MODES     (TRIG_MODES),
  .PEER_SEL       (PEER_SEL),
  .EXT_ACTIVE_HIGH(EXT_ACTIVE_HIGH)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .wr_strb     (wr_strb),
  .commit_trig (commit_trig),
  .rd_addr     (rd_addr),
  .rd_data     (rd_data),
  .reg_values  (reg_values),
  .reg_wr_pulse(reg_wr_pulse)
);

// File: tb/wdc_reg_group_bench.sv
module wdc_reg_group_bench;

  logic         clk;
  logic         rst_n;
  logic         wr_en;
  logic [3:0]   wr_addr;
  logic [31:0]  wr_data;
  logic [3:0]   wr_strb;
  logic         commit_trig;
  logic [3:0]   rd_addr;
  logic [31:0]  rd_data;
  logic [319:0] reg_values;
  logic [4:0]   reg_wr_pulse;

  int n_chk  = 0;
  int n_fail = 0;

  wdc_reg_group u_wdc_reg_group (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_strb     (wr_strb),
    .commit_trig (commit_trig),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .reg_values  (reg_values),
    .reg_wr_pulse(reg_wr_pulse)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [3:0]  req;
    logic        we;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [3:0]  strb;
    logic        ext;
    logic [4:0]  exp_pulse;
    logic [3:0]  chk_addr;
    logic [31:0] exp_rd;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  1'b1, 4'd0,  32'h11111111, 4'hF, 1'b0, 5'b00000, 4'd0,  32'h00000000}, // R2 staged only
    '{4'd3,  1'b1, 4'd1,  32'h22222222, 4'hF, 1'b0, 5'b00001, 4'd0,  32'h11111111}, // R3 self commit
    '{4'd8,  1'b0, 4'd0,  32'h0,        4'h0, 1'b0, 5'b00000, 4'd1,  32'h22222222}, // R8 one-cycle pulse
    '{4'd4,  1'b1, 4'd0,  32'hAAAAAAAA, 4'h5, 1'b0, 5'b00000, 4'd0,  32'h11111111}, // R4 partial staged
    '{4'd4,  1'b1, 4'd1,  32'hBBBBBBBB, 4'h2, 1'b0, 5'b00001, 4'd0,  32'h11AA11AA}, // R4 merged bytes
    '{4'd4,  1'b0, 4'd0,  32'h0,        4'h0, 1'b0, 5'b00000, 4'd1,  32'h2222BB22}, // R4 top word merge
    '{4'd2,  1'b1, 4'd2,  32'h33333333, 4'hF, 1'b0, 5'b00000, 4'd2,  32'h00000000}, // R2 reg1 staged
    '{4'd2,  1'b1, 4'd5,  32'h44444444, 4'hF, 1'b0, 5'b00000, 4'd5,  32'h00000000}, // R2 reg2 staged
    '{4'd5,  1'b1, 4'd9,  32'h55555555, 4'hF, 1'b0, 5'b10110, 4'd2,  32'h33333333}, // R5 group commit
    '{4'd5,  1'b0, 4'd0,  32'h0,        4'h0, 1'b0, 5'b00000, 4'd5,  32'h44444444}, // R5 reg2 result
    '{4'd9,  1'b0, 4'd0,  32'h0,        4'h0, 1'b0, 5'b00000, 4'd9,  32'h55555555}, // R9 trigger reg data
    '{4'd7,  1'b1, 4'd9,  32'h66666666, 4'hF, 1'b0, 5'b10000, 4'd2,  32'h33333333}, // R7 nothing pending
    '{4'd6,  1'b1, 4'd6,  32'h77777777, 4'hF, 1'b0, 5'b00000, 4'd6,  32'h00000000}, // R6 reg3 staged
    '{4'd6,  1'b0, 4'd0,  32'h0,        4'h0, 1'b1, 5'b01000, 4'd6,  32'h77777777}, // R6 external commit
    '{4'd7,  1'b0, 4'd0,  32'h0,        4'h0, 1'b1, 5'b00000, 4'd6,  32'h77777777}, // R7 ext, nothing pending
    '{4'd10, 1'b1, 4'd7,  32'h88888888, 4'hF, 1'b1, 5'b01000, 4'd7,  32'h88888888}, // R10 write with trigger
    '{4'd11, 1'b1, 4'd12, 32'hFFFFFFFF, 4'hF, 1'b0, 5'b00000, 4'd12, 32'h00000000}, // R11 unmapped
    '{4'd9,  1'b1, 4'd8,  32'h12345678, 4'hF, 1'b0, 5'b10000, 4'd8,  32'h12345678}, // R9 direct write
    '{4'd2,  1'b1, 4'd3,  32'h99999999, 4'hF, 1'b0, 5'b00000, 4'd3,  32'h00000000}, // R2 reg1 word1 staged
    '{4'd5,  1'b1, 4'd8,  32'h00000000, 4'hF, 1'b0, 5'b10000, 4'd3,  32'h00000000}, // R5 low word no commit
    '{4'd5,  1'b1, 4'd9,  32'h00000001, 4'hF, 1'b0, 5'b10010, 4'd3,  32'h99999999}  // R5 top word commit
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [3:0] a, input logic [31:0] d,
                       input logic [3:0] s, input logic ext, input logic [3:0] ra);
    wr_en       = we;
    wr_addr     = a;
    wr_data     = d;
    wr_strb     = s;
    commit_trig = ext;
    rd_addr     = ra;
  endtask

  task automatic idle(input logic [3:0] ra);
    drive(1'b0, 4'd0, 32'h0, 4'h0, 1'b0, ra);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    idle(4'd0);
    repeat (3) @(negedge clk);
    // R1 values during reset
    check("R1", {reg_values[63:0]}, 64'h0);
    check("R1", {59'h0, reg_wr_pulse}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 after release
    check("R1", {32'h0, rd_data}, 64'h0);
    check("R1", {reg_values[319:256]}, 64'h0);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i > 0)
        check($sformatf("R%0d", VECS[i-1].req), {32'h0, rd_data}, {32'h0, VECS[i-1].exp_rd});
      drive(VECS[i].we, VECS[i].addr, VECS[i].data, VECS[i].strb, VECS[i].ext, VECS[i].chk_addr);
      #1;
      check($sformatf("R%0d", VECS[i].req), {59'h0, reg_wr_pulse}, {59'h0, VECS[i].exp_pulse});
    end
    @(negedge clk);
    check($sformatf("R%0d", VECS[NV-1].req), {32'h0, rd_data}, {32'h0, VECS[NV-1].exp_rd});
    idle(4'd0);

    // R1: staged data lost across reset
    @(negedge clk);
    drive(1'b1, 4'd0, 32'hAAAAAAAA, 4'hF, 1'b0, 4'd0);
    @(negedge clk);
    idle(4'd0);
    #1 rst_n = 1'b0;
    #1 check("R1", reg_values[63:0], 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 4'd1, 32'h55555555, 4'hF, 1'b0, 4'd0);
    @(negedge clk);
    check("R1", {32'h0, rd_data}, 64'h0);
    check("R3", reg_values[63:0], 64'h55555555_00000000);
    idle(4'd0);

    // R6: value unchanged in the trigger cycle, new the cycle after
    @(negedge clk);
    drive(1'b1, 4'd6, 32'hCAFEF00D, 4'hF, 1'b0, 4'd6);
    @(negedge clk);
    drive(1'b0, 4'd0, 32'h0, 4'h0, 1'b1, 4'd6);
    #1;
    check("R6", {59'h0, reg_wr_pulse}, {59'h0, 5'b01000});
    check("R6", {32'h0, rd_data}, 64'h0);
    @(negedge clk);
    idle(4'd6);
    check("R6", {32'h0, rd_data}, {32'h0, 32'hCAFEF00D});

    // R4: top-word write with no strobes commits but changes nothing
    @(negedge clk);
    drive(1'b1, 4'd1, 32'hDEADBEEF, 4'h0, 1'b0, 4'd1);
    #1;
    check("R4", {59'h0, reg_wr_pulse}, {59'h0, 5'b00001});
    @(negedge clk);
    idle(4'd1);
    check("R4", {32'h0, rd_data}, {32'h0, 32'h55555555});
    #1;
    check("R8", {59'h0, reg_wr_pulse}, 64'h0);

    @(negedge clk);
    finish_run();
  end

endmodule